// File: doc/BRIEF.md
# Latched Interrupt Enable/Status Controller

This block gathers a few interrupt source lines into one level-sensitive interrupt for a parent controller. Each source has a pending flag, set when a rising edge appears on its line, and an enable bit. The output is high while any source is both pending and enabled. Software sees the flags and enables through a 32-bit register port. A write of one clears a pending flag. Reads return data one cycle after the request.

The layout is fixed when the block is built. In the combined layout, one word at byte offset 0x0 holds both halves: the enables sit in the low half and each pending flag sits 16 bits above its enable. In the split layout, enables and flags are separate words at 0x0 and 0x4. A parameter chooses which of the two is at 0x0, and both words use the same bit positions. The number of sources (2 to 7) and the bit position of the first source are parameters.

Top module: `irq_latch_ctl`

## Requirements
- R1: A synchronous active-high reset clears every enable, every pending flag, `irq_out` and `rd_data`.
- R2: In the combined layout, word 0 (`addr_word` = 0) holds the enable of source i at bit FIRST_BIT+i and its pending flag at bit FIRST_BIT+i+16. A write to word 0 loads the enables from the low half.
- R3: A pending flag is set at the clock edge that first samples its source high after a low sample. A line that stays high, falls, or is held high through reset sets nothing.
- R4: Writing 1 to a pending-flag position clears that flag. Writing 0 leaves the flag as it was, so a combined-word write can reload the enables and clear exactly the flags it names.
- R5: If a rising edge and a clear of the same flag fall in the same cycle, the flag stays set.
- R6: Flags latch whatever the enables hold. Enabling a source whose flag is already pending raises `irq_out` at the same edge that takes the write.
- R7: `irq_out` is a register equal to the OR of (pending AND enable) over all sources, updated at the same edge as the state. It stays high until every enabled pending flag is cleared or disabled.
- R8: Bits outside the configured source range, and words that no layout uses, read as zero, and writes to them have no effect.
- R9: `rd_data` is loaded at the edge that samples `rd_en`. It shows the state as it was before any write in that same cycle, and it holds its value while `rd_en` is low.
- R10: In the split layout, the enable word and the flag word are at `addr_word` 0 and 1. ENABLE_WORD_LOW=1 puts the enables at 0, and 0 puts the flags at 0. A flag sits at the same bit position as its enable, and writing 1 to a flag position clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | NUM_SRC | Interrupt source lines; rising edges are latched |
| wr_en | input | 1 | Register write strobe, single cycle |
| rd_en | input | 1 | Register read request; data follows one cycle later |
| addr_word | input | 2 | Word index (byte offset divided by 4) |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, registered |
| irq_out | output | 1 | Level interrupt to the parent controller |

## Verification
A rising edge on a source can land in the same cycle as a write that clears that source's flag. The bench brings about this collision by dropping the line, then raising it again at the same falling edge at which it drives a write-one-to-clear for that flag. Reading the flag back as still set, with `irq_out` still high, shows that the set took priority. A read issued in the same cycle as a clearing write is also checked: it must return the value from before the write, and only a second read shows the cleared flag.

// File: rtl/irq_latch_ctl.sv
module irq_latch_ctl #(
  parameter int NUM_SRC         = 4,
  parameter int FIRST_BIT       = 0,
  parameter bit SPLIT_LAYOUT    = 1'b0,
  parameter bit ENABLE_WORD_LOW = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [1:0]         addr_word,
  input  logic [31:0]        wr_data,
  output logic [31:0]        rd_data,
  output logic               irq_out
);

  localparam int         PEND_POS  = SPLIT_LAYOUT ? FIRST_BIT : FIRST_BIT + 16;
  localparam logic [1:0] EN_WORD   = (SPLIT_LAYOUT && !ENABLE_WORD_LOW) ? 2'd1 : 2'd0;
  localparam logic [1:0] PEND_WORD = (SPLIT_LAYOUT &&  ENABLE_WORD_LOW) ? 2'd1 : 2'd0;

  logic [NUM_SRC-1:0] src_d, en_q, pend_q;
  logic [NUM_SRC-1:0] rise, clr_mask, en_nx, pend_nx;
  logic [31:0]        en_view, pend_view, rd_nx;
  logic               hit_en, hit_pend;

  assign hit_en   = (addr_word == EN_WORD);
  assign hit_pend = (addr_word == PEND_WORD);
  assign rise     = src_in & ~src_d;
  assign clr_mask = (wr_en && hit_pend) ? wr_data[PEND_POS +: NUM_SRC] : '0;
  assign en_nx    = (wr_en && hit_en) ? wr_data[FIRST_BIT +: NUM_SRC] : en_q;
  assign pend_nx  = (pend_q & ~clr_mask) | rise;

  always_comb begin
    en_view   = '0;
    pend_view = '0;
    en_view[FIRST_BIT +: NUM_SRC]  = en_q;
    pend_view[PEND_POS +: NUM_SRC] = pend_q;
  end

  assign rd_nx = (hit_en ? en_view : 32'd0) | (hit_pend ? pend_view : 32'd0);

  always_ff @(posedge clk) src_d <= src_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      pend_q  <= '0;
      irq_out <= 1'b0;
      rd_data <= '0;
    end else begin
      en_q    <= en_nx;
      pend_q  <= pend_nx;
      irq_out <= |(en_nx & pend_nx);
      if (rd_en) rd_data <= rd_nx;
    end
  end

  logic unused_bits;
  assign unused_bits = ^wr_data;

endmodule

// File: rtl/irq_latch_ctl_checker.sv
module irq_latch_ctl_checker #(
  parameter int NUM_SRC = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] src_in,
  input logic [NUM_SRC-1:0] src_d,
  input logic [NUM_SRC-1:0] en_q,
  input logic [NUM_SRC-1:0] pend_q,
  input logic [NUM_SRC-1:0] clr_mask,
  input logic               irq_out
);

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!irq_out && en_q == '0 && pend_q == '0));

  assert_edge_latches_R3: assert property (@(posedge clk) disable iff (rst)
    ((src_in & ~src_d) != '0) |=>
      ((pend_q & $past(src_in & ~src_d)) == $past(src_in & ~src_d)));

  assert_clear_only_by_one_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (($past(pend_q) & ~pend_q & ~$past(clr_mask)) == '0));

  assert_set_beats_clear_R5: assert property (@(posedge clk) disable iff (rst)
    ((src_in & ~src_d & clr_mask) != '0) |=>
      ((pend_q & $past(src_in & ~src_d & clr_mask)) != '0));

  assert_masked_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (en_q == '0) |-> !irq_out);

  assert_output_matches_R7: assert property (@(posedge clk) disable iff (rst)
    irq_out == |(pend_q & en_q));

endmodule

bind irq_latch_ctl irq_latch_ctl_checker #(.NUM_SRC(NUM_SRC)) chk (
  .clk(clk), .rst(rst), .src_in(src_in), .src_d(src_d), .en_q(en_q),
  .pend_q(pend_q), .clr_mask(clr_mask), .irq_out(irq_out)
);

// File: tb/irq_latch_ctl_test.sv
module irq_latch_ctl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  src_a = 2'b11;
  logic [3:0]  src_b = 4'b0000;
  logic        wr_a = 1'b0, wr_b = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_a, rd_b;
  logic        irq_a, irq_b;
  int          total = 0, fails = 0;

  always #10 clk = ~clk;

  irq_latch_ctl #(.NUM_SRC(2), .FIRST_BIT(4), .SPLIT_LAYOUT(1'b0), .ENABLE_WORD_LOW(1'b1)) uut (
    .clk(clk), .rst(rst), .src_in(src_a), .wr_en(wr_a), .rd_en(rd_en),
    .addr_word(addr), .wr_data(wdata), .rd_data(rd_a), .irq_out(irq_a));

  irq_latch_ctl #(.NUM_SRC(4), .FIRST_BIT(0), .SPLIT_LAYOUT(1'b1), .ENABLE_WORD_LOW(1'b0)) uut_split (
    .clk(clk), .rst(rst), .src_in(src_b), .wr_en(wr_b), .rd_en(rd_en),
    .addr_word(addr), .wr_data(wdata), .rd_data(rd_b), .irq_out(irq_b));

  // {src, wr, wdata, exp_irq, exp_rd} for uut: enables [5:4], flags [21:20]
  localparam int NV = 10;
  localparam logic [67:0] VEC [NV] = '{
    {2'b00, 1'b1, 32'h0000_0030, 1'b0, 32'h0000_0030},  // R2 enables load
    {2'b01, 1'b0, 32'h0000_0000, 1'b1, 32'h0010_0030},  // R3 edge on src0, R7
    {2'b01, 1'b1, 32'h0000_0030, 1'b1, 32'h0010_0030},  // R4 zero keeps flag
    {2'b00, 1'b1, 32'h0010_0030, 1'b0, 32'h0000_0030},  // R4 one clears
    {2'b10, 1'b1, 32'h0000_0000, 1'b0, 32'h0020_0000},  // R6 latch while disabled
    {2'b10, 1'b1, 32'h0000_0020, 1'b1, 32'h0020_0020},  // R6 enable raises irq
    {2'b00, 1'b1, 32'hFFFF_FFFF, 1'b0, 32'h0000_0030},  // R8 unused bits ignored
    {2'b11, 1'b0, 32'h0000_0000, 1'b1, 32'h0030_0030},  // R3 both edges
    {2'b00, 1'b1, 32'h0010_0030, 1'b1, 32'h0020_0030},  // R7 still high
    {2'b00, 1'b1, 32'h0020_0030, 1'b0, 32'h0000_0030}   // R7 falls on last clear
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [1:0] w);
    @(negedge clk); addr = w; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic write_b(input logic [1:0] w, input logic [31:0] d);
    @(negedge clk); addr = w; wdata = d; wr_b = 1'b1;
    @(negedge clk); wr_b = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    do_read(2'd0);
    check("R1 rd_data", rd_a, 32'h0);
    check("R1 irq_out", {31'd0, irq_a}, 32'h0);
    check("R1 split irq_out", {31'd0, irq_b}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      src_a = VEC[i][67:66];
      addr  = 2'd0;
      wdata = VEC[i][64:33];
      wr_a  = VEC[i][65];
      @(negedge clk); wr_a = 1'b0; addr = 2'd0; rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0;
      check($sformatf("R2/R4/R6/R7 vector %0d irq", i), {31'd0, irq_a}, {31'd0, VEC[i][32]});
      check($sformatf("R2/R4/R8 vector %0d read", i), rd_a, VEC[i][31:0]);
    end

    // R5: edge and clear of the same flag in one cycle
    @(negedge clk); src_a = 2'b01;
    @(negedge clk); src_a = 2'b00;
    @(negedge clk); src_a = 2'b01; addr = 2'd0; wdata = 32'h0010_0030; wr_a = 1'b1;
    @(negedge clk); wr_a = 1'b0;
    do_read(2'd0);
    check("R5 flag kept", rd_a, 32'h0010_0030);
    check("R5 irq kept", {31'd0, irq_a}, 32'h1);

    // R9: read in the same cycle as a clearing write sees the old state
    @(negedge clk); addr = 2'd0; wdata = 32'h0010_0030; wr_a = 1'b1; rd_en = 1'b1;
    @(negedge clk); wr_a = 1'b0; rd_en = 1'b0;
    check("R9 old value", rd_a, 32'h0010_0030);
    @(negedge clk);
    check("R9 hold without rd_en", rd_a, 32'h0010_0030);
    do_read(2'd0);
    check("R9 new value", rd_a, 32'h0000_0030);
    check("R4 irq after clear", {31'd0, irq_a}, 32'h0);

    // R8: unused words
    @(negedge clk); addr = 2'd2; wdata = 32'hFFFF_FFFF; wr_a = 1'b1;
    @(negedge clk); addr = 2'd1;
    @(negedge clk); wr_a = 1'b0;
    do_read(2'd2);
    check("R8 unused word reads zero", rd_a, 32'h0);
    do_read(2'd0);
    check("R8 no side effect", rd_a, 32'h0000_0030);

    // R10: split instance, flags at word 0, enables at word 1
    @(negedge clk); src_b = 4'b0100;
    @(negedge clk); src_b = 4'b0000;
    do_read(2'd0);
    check("R10 split flag", rd_b, 32'h0000_0004);
    check("R6 split irq masked", {31'd0, irq_b}, 32'h0);
    write_b(2'd1, 32'h0000_0004);
    check("R10 split irq after enable", {31'd0, irq_b}, 32'h1);
    do_read(2'd1);
    check("R10 split enable word", rd_b, 32'h0000_0004);
    write_b(2'd0, 32'h0000_0000);
    do_read(2'd0);
    check("R10 split zero keeps flag", rd_b, 32'h0000_0004);
    write_b(2'd0, 32'h0000_0004);
    check("R10 split irq after clear", {31'd0, irq_b}, 32'h0);
    do_read(2'd0);
    check("R10 split flag cleared", rd_b, 32'h0);
    do_read(2'd2);
    check("R8 split unused word", rd_b, 32'h0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog R1: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule